// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is the serial front end of an LED display and keypad controller. A fast system clock oversamples the two-wire bus lines, so the block can find START, repeated START and STOP conditions, take in bytes and acknowledge them. The whole register file lives in the block: digit memory, decode enable, global and per-pair intensity, scan limit, shutdown, feature, test and self-address registers. Diagnostic and key results come in from outside and can be read back over the bus.

A host writes the device address with the direction bit at 0, then a command byte that loads the register pointer, then any number of data bytes. Each data byte goes to the register at the pointer, and the pointer then steps by one. To read, the host first sets the pointer with a write, then issues a repeated START with the direction bit at 1 and clocks out bytes, the pointer stepping after each one. The host ends the read by not acknowledging the last byte. The register contents and a one-cycle write strobe (address and data) go to the display and keyscan logic.

The device address is 0000000 after reset. A write to the self-address register moves the two low address bits to the levels on two strap inputs.

Top module: `ledKeyRegSlave`

## Requirements
- R1: After reset, all stored registers read 0, SDA is released (sdaOe = 0) and the device address is 7'b0000000.
- R2: An address byte whose upper seven bits match the device address is acknowledged. A mismatch is not acknowledged, and all bytes up to the next START are ignored: no acknowledge, no write.
- R3: In a write, the byte after the address (R/W = 0) loads the register pointer. Each later data byte is written to the register at the pointer and is acknowledged, and the pointer then increments. Digit k (1..8) sits at address k, and its value appears on digitData[8*(k-1)+:8].
- R4: After a repeated START with R/W = 1, the slave sends the register at the pointer MSB first, and the pointer increments after each byte. A master ACK (SDA low) fetches the next byte. A NACK makes the slave release SDA and ignore the bus until the next START.
- R5: A write to 0x0A stores the byte in globalInt and copies its low nibble into both nibbles of the four pair-intensity registers 0x10..0x13 (pairInt[8*j+:8] = register 0x10+j). A write to a single pair register changes only that one.
- R6: A write to the shutdown register 0x0C with bit 7 = 0 clears the feature register 0x0E to 0. With bit 7 = 1 the feature register keeps its value.
- R7: A write to the feature register with bit 1 = 1 stores that byte and returns decode 0x09, global intensity 0x0A, scan limit 0x0B, shutdown 0x0C, test 0x0F and the pair-intensity registers to 0. Digit registers keep their contents.
- R8: A write to 0x2D with bit 0 = 1 sets the device address to {5'b00000, strapOpen[1], strapOpen[0]}, sampled at that write. A strap input is 1 for an open node and 0 for a shorted node. A write with bit 0 = 0 restores address 0000000.
- R9: A STOP returns the slave to idle and leaves the pointer unchanged, so a read that follows straight after START with R/W = 1 begins at the pointer left by the last transfer.
- R10: A bus-line level only takes effect once the synchronised input has held it for two samples, so a one-clock pulse on SCL causes no bit to be taken.
- R11: Registers 0x14..0x1B read diagIn[8*i+:8] (i = address − 0x14), and 0x1C/0x1D read keyIn[7:0]/keyIn[15:8]. A bus write to these addresses does not change what they read. An address with no register (for example 0x0D or 0x1E) reads 0.
- R12: Each accepted data byte raises wrStrobe for exactly one clock, with wrAddr and wrData giving the register address and the byte. Address and command bytes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| strapOpen | input | 2 | Address strap levels, bit1 → A1, bit0 → A0 (open = 1) |
| keyIn | input | 16 | Debounced key states, low byte at 0x1C |
| diagIn | input | 64 | LED diagnostic results, byte i at 0x14+i |
| digitData | output | 64 | Digit registers, byte k-1 is digit register k |
| decodeEn | output | 8 | Decode enable register |
| globalInt | output | 8 | Global intensity register |
| scanLimit | output | 8 | Scan limit register |
| shutdownReg | output | 8 | Shutdown register |
| featureReg | output | 8 | Feature register |
| testReg | output | 8 | Test mode register |
| pairInt | output | 32 | Pair intensity registers, byte j is 0x10+j |
| wrStrobe | output | 1 | One-cycle pulse per written data byte |
| wrAddr | output | 8 | Register address of the current write |
| wrData | output | 8 | Data byte of the current write |

## Verification
The bench uses the default parameters: eight digits, a two-flop synchroniser and a two-sample hold filter. With these the whole address map exists, so auto-increment runs across every digit register, the global write fans out to all four pair registers, and the read-only diagnostic and key window sits next to unmapped addresses. The two-sample filter lets a single-clock SCL glitch be injected in the middle of each data bit and shown to leave the written byte unchanged. Running the strap-driven retargeting last covers both the old address no longer answering and the new one taking over.

// File: rtl/ledKeyRegPkg.sv
package ledKeyRegPkg;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrAddr;
    logic [7:0] wrData;
  } regStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  localparam logic [7:0] A_DIGIT_BASE = 8'h01;
  localparam logic [7:0] A_DECODE     = 8'h09;
  localparam logic [7:0] A_GLOBAL     = 8'h0A;
  localparam logic [7:0] A_SCAN       = 8'h0B;
  localparam logic [7:0] A_SHUTDOWN   = 8'h0C;
  localparam logic [7:0] A_FEATURE    = 8'h0E;
  localparam logic [7:0] A_TEST       = 8'h0F;
  localparam logic [7:0] A_PAIR_BASE  = 8'h10;
  localparam logic [7:0] A_DIAG_BASE  = 8'h14;
  localparam logic [7:0] A_KEY_LO     = 8'h1C;
  localparam logic [7:0] A_KEY_HI     = 8'h1D;
  localparam logic [7:0] A_SELFADDR   = 8'h2D;

endpackage

// File: rtl/busLineFilter.sv
module busLineFilter #(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_SAMPLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  logic [SYNC_STAGES-1:0]  syncQ;
  logic [HOLD_SAMPLES-1:0] histQ;
  logic                    syncedBit;

  assign syncedBit = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      histQ   <= '1;
      lineOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      histQ <= {histQ[HOLD_SAMPLES-2:0], syncedBit};
      if (&histQ)       lineOut <= 1'b1;
      else if (~|histQ) lineOut <= 1'b0;
    end
  end

  // R10: a change of the filtered level is never followed by another one
  p_no_double_toggle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineOut) |=> $stable(lineOut));

endmodule

// File: rtl/busCtrl.sv
module busCtrl
  import ledKeyRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [6:0] devAddr,
  input  logic [7:0] rdByte,
  output logic [7:0] regPtr,
  output logic       sdaOe,
  output regStrobe_t strobe
);

  busState_t  state;
  logic       sclD, sdaD;
  logic [3:0] bitCnt;
  logic [7:0] rxSr, txSr;
  logic       rwBit, masterAck;
  logic       startEv, stopEv, sclRise, sclFall;

  assign startEv = sclF && sclD && sdaD && !sdaF;
  assign stopEv  = sclF && sclD && !sdaD && sdaF;
  assign sclRise = sclF && !sclD;
  assign sclFall = !sclF && sclD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sclD      <= 1'b1;
      sdaD      <= 1'b1;
      bitCnt    <= '0;
      rxSr      <= '0;
      txSr      <= '0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      regPtr    <= '0;
      sdaOe     <= 1'b0;
      strobe    <= '0;
    end else begin
      sclD        <= sclF;
      sdaD        <= sdaF;
      strobe.wrEn <= 1'b0;
      if (startEv) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopEv) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (sclRise) begin
              rxSr   <= {rxSr[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (rxSr[7:1] == devAddr) begin
                  rwBit <= rxSr[0];
                  sdaOe <= 1'b1;
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                regPtr <= rxSr;
                sdaOe  <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                strobe.wrEn   <= 1'b1;
                strobe.wrAddr <= regPtr;
                strobe.wrData <= rxSr;
                regPtr        <= regPtr + 8'd1;
                sdaOe         <= 1'b1;
                state         <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (rwBit) begin
                txSr   <= {rdByte[6:0], 1'b0};
                sdaOe  <= ~rdByte[7];
                regPtr <= regPtr + 8'd1;
                bitCnt <= 4'd1;
                state  <= ST_RDATA;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WDATA_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                state  <= ST_RACK;
              end else begin
                sdaOe  <= ~txSr[7];
                txSr   <= {txSr[6:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (sclRise) masterAck <= ~sdaF;
            else if (sclFall) begin
              if (masterAck) begin
                txSr   <= {rdByte[6:0], 1'b0};
                sdaOe  <= ~rdByte[7];
                regPtr <= regPtr + 8'd1;
                bitCnt <= 4'd1;
                state  <= ST_RDATA;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
          default: sdaOe <= 1'b0;
        endcase
      end
    end
  end

  // R2: an idle slave never holds the data line
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R3: the pointer has moved past the register just written
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (regPtr == strobe.wrAddr + 8'd1));

  // R12: write strobe lasts a single cycle
  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !strobe.wrEn);

  // R9: a STOP leaves the pointer where it was
  p_stop_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (regPtr == $past(regPtr)));

  // R4: a NACKed byte returns the slave to idle with the line released
  p_nack_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclFall && !masterAck && !startEv && !stopEv) |=> (!sdaOe && state == ST_IDLE));

endmodule

// File: rtl/regBank.sv
module regBank
  import ledKeyRegPkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [7:0]            rdAddr,
  input  logic [1:0]            strapOpen,
  input  logic [15:0]           keyIn,
  input  logic [8*DIGITS-1:0]   diagIn,
  output logic [7:0]            rdByte,
  output logic [6:0]            devAddr,
  output logic [8*DIGITS-1:0]   digitData,
  output logic [7:0]            decodeEn,
  output logic [7:0]            globalInt,
  output logic [7:0]            scanLimit,
  output logic [7:0]            shutdownReg,
  output logic [7:0]            featureReg,
  output logic [7:0]            testReg,
  output logic [4*DIGITS-1:0]   pairInt
);

  localparam int PAIRS = DIGITS / 2;

  logic [7:0] digitQ [DIGITS];
  logic [7:0] pairQ  [PAIRS];
  logic       selfEn;
  logic [1:0] strapQ;
  logic       ctrlClear;

  assign ctrlClear = strobe.wrEn && strobe.wrAddr == A_FEATURE && strobe.wrData[1];
  assign devAddr   = selfEn ? {5'b00000, strapQ} : 7'b0000000;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) digitQ[i] <= '0;
      else if (strobe.wrEn && strobe.wrAddr == A_DIGIT_BASE + 8'(i)) digitQ[i] <= strobe.wrData;
    end
    assign digitData[8*i +: 8] = digitQ[i];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pairQ[j] <= '0;
      else if (ctrlClear) pairQ[j] <= '0;
      else if (strobe.wrEn && strobe.wrAddr == A_GLOBAL) pairQ[j] <= {2{strobe.wrData[3:0]}};
      else if (strobe.wrEn && strobe.wrAddr == A_PAIR_BASE + 8'(j)) pairQ[j] <= strobe.wrData;
    end
    assign pairInt[8*j +: 8] = pairQ[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decodeEn    <= '0;
      globalInt   <= '0;
      scanLimit   <= '0;
      shutdownReg <= '0;
      featureReg  <= '0;
      testReg     <= '0;
      selfEn      <= 1'b0;
      strapQ      <= '0;
    end else if (strobe.wrEn) begin
      case (strobe.wrAddr)
        A_DECODE: decodeEn  <= strobe.wrData;
        A_GLOBAL: globalInt <= strobe.wrData;
        A_SCAN:   scanLimit <= strobe.wrData;
        A_TEST:   testReg   <= strobe.wrData;
        A_SHUTDOWN: begin
          shutdownReg <= strobe.wrData;
          if (!strobe.wrData[7]) featureReg <= '0;
        end
        A_FEATURE: begin
          featureReg <= strobe.wrData;
          if (strobe.wrData[1]) begin
            decodeEn    <= '0;
            globalInt   <= '0;
            scanLimit   <= '0;
            shutdownReg <= '0;
            testReg     <= '0;
          end
        end
        A_SELFADDR: begin
          selfEn <= strobe.wrData[0];
          if (strobe.wrData[0]) strapQ <= strapOpen;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (rdAddr == A_DIGIT_BASE + 8'(i)) rdByte = digitQ[i];
      if (rdAddr == A_DIAG_BASE + 8'(i))  rdByte = diagIn[8*i +: 8];
    end
    for (int j = 0; j < PAIRS; j++) begin
      if (rdAddr == A_PAIR_BASE + 8'(j)) rdByte = pairQ[j];
    end
    case (rdAddr)
      A_DECODE:   rdByte = decodeEn;
      A_GLOBAL:   rdByte = globalInt;
      A_SCAN:     rdByte = scanLimit;
      A_SHUTDOWN: rdByte = shutdownReg;
      A_FEATURE:  rdByte = featureReg;
      A_TEST:     rdByte = testReg;
      A_KEY_LO:   rdByte = keyIn[7:0];
      A_KEY_HI:   rdByte = keyIn[15:8];
      A_SELFADDR: rdByte = {7'b0, selfEn};
      default: ;
    endcase
  end

  // R5: a global write leaves every pair register holding the doubled nibble
  p_fanout_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrAddr == A_GLOBAL) |=> (pairInt == {(2*PAIRS){$past(strobe.wrData[3:0])}}));

  // R6: shutdown write with bit 7 low empties the feature register
  p_feature_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrAddr == A_SHUTDOWN && !strobe.wrData[7]) |=> (featureReg == 8'h00));

  // R7: control reset keeps digit contents
  p_regres_digits_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlClear |=> ($stable(digitData) && decodeEn == 8'h00 && scanLimit == 8'h00 && pairInt == '0));

  // R8: enabling self addressing picks up the strap levels
  p_selfaddr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrAddr == A_SELFADDR && strobe.wrData[0]) |=> (devAddr == {5'b00000, $past(strapOpen)}));

endmodule

// File: rtl/ledKeyRegSlave.sv
module ledKeyRegSlave
  import ledKeyRegPkg::*;
#(
  parameter int DIGITS       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_SAMPLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [1:0]          strapOpen,
  input  logic [15:0]         keyIn,
  input  logic [8*DIGITS-1:0] diagIn,
  output logic [8*DIGITS-1:0] digitData,
  output logic [7:0]          decodeEn,
  output logic [7:0]          globalInt,
  output logic [7:0]          scanLimit,
  output logic [7:0]          shutdownReg,
  output logic [7:0]          featureReg,
  output logic [7:0]          testReg,
  output logic [4*DIGITS-1:0] pairInt,
  output logic                wrStrobe,
  output logic [7:0]          wrAddr,
  output logic [7:0]          wrData
);

  logic       sclF, sdaF;
  logic [6:0] devAddr;
  logic [7:0] rdByte, regPtr;
  regStrobe_t strobe;

  busLineFilter #(.SYNC_STAGES(SYNC_STAGES), .HOLD_SAMPLES(HOLD_SAMPLES)) u_sclFilt (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineOut(sclF));

  busLineFilter #(.SYNC_STAGES(SYNC_STAGES), .HOLD_SAMPLES(HOLD_SAMPLES)) u_sdaFilt (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineOut(sdaF));

  busCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .devAddr(devAddr),
    .rdByte(rdByte), .regPtr(regPtr), .sdaOe(sdaOe), .strobe(strobe));

  regBank #(.DIGITS(DIGITS)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(regPtr), .strapOpen(strapOpen),
    .keyIn(keyIn), .diagIn(diagIn), .rdByte(rdByte), .devAddr(devAddr),
    .digitData(digitData), .decodeEn(decodeEn), .globalInt(globalInt),
    .scanLimit(scanLimit), .shutdownReg(shutdownReg), .featureReg(featureReg),
    .testReg(testReg), .pairInt(pairInt));

  assign wrStrobe = strobe.wrEn;
  assign wrAddr   = strobe.wrAddr;
  assign wrData   = strobe.wrData;

endmodule

// File: tb/sim_ledKeyRegSlave.sv
module sim_ledKeyRegSlave;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaLine;
  logic [1:0]  strapOpen = 2'b00;
  logic [15:0] keyIn = 16'h0000;
  logic [63:0] diagIn = 64'h0;
  logic [63:0] digitData;
  logic [7:0]  decodeEn, globalInt, scanLimit, shutdownReg, featureReg, testReg;
  logic [31:0] pairInt;
  logic        wrStrobe;
  logic [7:0]  wrAddr, wrData;

  int tests = 0, fails = 0, strobeCnt = 0;
  bit done = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  bit allAck;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  ledKeyRegSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapOpen(strapOpen), .keyIn(keyIn), .diagIn(diagIn), .digitData(digitData),
    .decodeEn(decodeEn), .globalInt(globalInt), .scanLimit(scanLimit),
    .shutdownReg(shutdownReg), .featureReg(featureReg), .testReg(testReg),
    .pairInt(pairInt), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData));

  always @(posedge clk) if (rstN && wrStrobe) strobeCnt <= strobeCnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); sdaM = 1'b0; qw(); sclM = 1'b0; qw();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1; qw();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (glitch) begin
        repeat (Q/2) @(negedge clk);
        sclM = 1'b1; @(negedge clk); sclM = 1'b0;
        repeat (Q/2 - 1) @(negedge clk);
      end else qw();
      sclM = 1'b1; qw(2); sclM = 1'b0; qw();
    end
    sdaM = 1'b1; qw(); sclM = 1'b1; qw();
    ack = !sdaLine;
    qw(); sclM = 1'b0; qw();
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; qw(); sclM = 1'b1; qw();
      b[i] = sdaLine;
      qw(); sclM = 1'b0; qw();
    end
    sdaM = mAck ? 1'b0 : 1'b1; qw(); sclM = 1'b1; qw(2); sclM = 1'b0; qw();
  endtask

  task automatic writeRegs(input logic [6:0] dev, input logic [7:0] cmd, input int n, input bit glitch = 0);
    bit a;
    allAck = 1;
    busStart();
    sendByte({dev, 1'b0}, 0, a); allAck &= a;
    sendByte(cmd, 0, a); allAck &= a;
    for (int i = 0; i < n; i++) begin sendByte(wbuf[i], glitch, a); allAck &= a; end
    busStop();
  endtask

  task automatic readRegs(input logic [6:0] dev, input logic [7:0] cmd, input int n);
    bit a;
    allAck = 1;
    busStart();
    sendByte({dev, 1'b0}, 0, a); allAck &= a;
    sendByte(cmd, 0, a); allAck &= a;
    busStart();
    sendByte({dev, 1'b1}, 0, a); allAck &= a;
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rbuf[i]);
    chk("R4 sda released after nack", {63'b0, sdaOe}, 64'h0);
    busStop();
  endtask

  task automatic t_reset();
    chk("R1 sdaOe", {63'b0, sdaOe}, 64'h0);
    chk("R1 digits", digitData, 64'h0);
    chk("R1 controls", {decodeEn, globalInt, scanLimit, shutdownReg, featureReg, testReg}, 64'h0);
    chk("R1 pairs", {32'b0, pairInt}, 64'h0);
  endtask

  task automatic t_writeDigits();
    int s0 = strobeCnt;
    for (int i = 0; i < 8; i++) wbuf[i] = 8'((i + 1) * 8'h11);
    writeRegs(7'h00, 8'h01, 8);
    chk("R2 R3 all bytes acked", {63'b0, allAck}, 64'h1);
    chk("R3 digits autoincrement", digitData, 64'h8877665544332211);
    chk("R12 one strobe per data byte", 64'(strobeCnt - s0), 64'd8);
  endtask

  task automatic t_readBack();
    readRegs(7'h00, 8'h03, 3);
    chk("R4 read acks", {63'b0, allAck}, 64'h1);
    chk("R4 read bytes", {40'b0, rbuf[0], rbuf[1], rbuf[2]}, {40'b0, 24'h334455});
  endtask

  task automatic t_stopKeepsPtr();
    bit a;
    logic [7:0] b;
    busStart();
    sendByte({7'h00, 1'b1}, 0, a);
    recvByte(0, b);
    busStop();
    chk("R9 read continues at kept pointer", {56'b0, b}, 64'h66);
  endtask

  task automatic t_wrongAddr();
    int s0 = strobeCnt;
    wbuf[0] = 8'hEE;
    writeRegs(7'h05, 8'h01, 1);
    chk("R2 mismatch not acked", {63'b0, allAck}, 64'h0);
    chk("R2 mismatch no write", digitData, 64'h8877665544332211);
    chk("R2 mismatch no strobe", 64'(strobeCnt - s0), 64'd0);
  endtask

  task automatic t_fanout();
    wbuf[0] = 8'h37;
    writeRegs(7'h00, 8'h0A, 1);
    chk("R5 global stored", {56'b0, globalInt}, 64'h37);
    chk("R5 fanout to pairs", {32'b0, pairInt}, 64'h77777777);
    wbuf[0] = 8'h5A;
    writeRegs(7'h00, 8'h11, 1);
    chk("R5 single pair write", {32'b0, pairInt}, 64'h77775A77);
  endtask

  task automatic t_shutdown();
    wbuf[0] = 8'h05; writeRegs(7'h00, 8'h0E, 1);
    wbuf[0] = 8'h81; writeRegs(7'h00, 8'h0C, 1);
    chk("R6 bit7=1 keeps feature", {48'b0, featureReg, shutdownReg}, 64'h0581);
    wbuf[0] = 8'h01; writeRegs(7'h00, 8'h0C, 1);
    chk("R6 bit7=0 clears feature", {48'b0, featureReg, shutdownReg}, 64'h0001);
  endtask

  task automatic t_regRes();
    wbuf[0] = 8'hFF; writeRegs(7'h00, 8'h09, 1);
    wbuf[0] = 8'h07; writeRegs(7'h00, 8'h0B, 1);
    wbuf[0] = 8'h01; writeRegs(7'h00, 8'h0F, 1);
    chk("R7 setup", {40'b0, decodeEn, scanLimit, testReg}, 64'hFF0701);
    wbuf[0] = 8'h02; writeRegs(7'h00, 8'h0E, 1);
    chk("R7 controls cleared", {decodeEn, globalInt, scanLimit, shutdownReg, testReg, 24'b0}, 64'h0);
    chk("R7 pairs cleared", {32'b0, pairInt}, 64'h0);
    chk("R7 feature kept", {56'b0, featureReg}, 64'h02);
    chk("R7 digits kept", digitData, 64'h8877665544332211);
  endtask

  task automatic t_readOnly();
    keyIn = 16'hA55A;
    diagIn = 64'h0123456789ABCDEF;
    readRegs(7'h00, 8'h1B, 4);
    chk("R11 diag key unmapped", {32'b0, rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 64'h015AA500);
    wbuf[0] = 8'hFF;
    writeRegs(7'h00, 8'h1C, 1);
    readRegs(7'h00, 8'h1C, 1);
    chk("R11 key write ignored", {56'b0, rbuf[0]}, 64'h5A);
    readRegs(7'h00, 8'h0D, 1);
    chk("R11 unmapped reads zero", {56'b0, rbuf[0]}, 64'h00);
    readRegs(7'h00, 8'h14, 1);
    chk("R11 diag digit0", {56'b0, rbuf[0]}, 64'hEF);
  endtask

  task automatic t_glitch();
    wbuf[0] = 8'hC3;
    writeRegs(7'h00, 8'h01, 1, 1);
    chk("R10 glitch ignored", {56'b0, digitData[7:0]}, 64'hC3);
  endtask

  task automatic t_selfAddr();
    bit a;
    strapOpen = 2'b10;
    wbuf[0] = 8'h00; writeRegs(7'h00, 8'h2D, 1);
    chk("R8 bit0=0 keeps address 0", {63'b0, allAck}, 64'h1);
    wbuf[0] = 8'h01; writeRegs(7'h00, 8'h2D, 1);
    strapOpen = 2'b01;
    busStart(); sendByte({7'h00, 1'b0}, 0, a); busStop();
    chk("R8 old address not acked", {63'b0, a}, 64'h0);
    wbuf[0] = 8'h9C; writeRegs(7'h02, 8'h08, 1);
    chk("R8 strap address acked", {63'b0, allAck}, 64'h1);
    chk("R8 strap address writes", {56'b0, digitData[63:56]}, 64'h9C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_writeDigits();
    t_readBack();
    t_stopKeepsPtr();
    t_wrongAddr();
    t_fanout();
    t_shutdown();
    t_regRes();
    t_readOnly();
    t_glitch();
    t_selfAddr();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule